// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block picks, for every CPU in a cluster, the single interrupt that should be delivered next. It keeps a bank of pending and active bits for each CPU. On every cycle it scans that CPU's candidates in ascending ID order and takes the one with the numerically smallest priority value, where a smaller value means more urgent. A request to the CPU is raised on the following clock edge if the winner clears the priority mask and the enables, and is not already being serviced.

Software-visible state arrives as flattened vectors: line enables, one priority byte per line, a target bitmask per line, and per-CPU masks. The CPU acknowledges the current winner with a strobe, which moves that interrupt from pending to active. The CPU finishes with an end-of-interrupt strobe that carries an ID, which clears that ID's active bit. A running priority per CPU reports the most urgent priority that is still active. Register decode of any bus is done outside this block.

Top module: `irq_prio_selector`

## Requirements
- R1: The selected ID for a CPU is the candidate with the smallest priority value. A candidate replaces the current best only when its value is strictly smaller, starting from 0xFF, so ties go to the lowest ID and a line whose priority is 0xFF is never selected.
- R2: A line i is a candidate for CPU c when all three hold: its enable bit is set; its pending bit in c's bank is set; and either i is below NUM_PRIVATE (32), or `multi_cpu_i` is low, or bit c of its target mask `irq_tgt_i[i*NUM_CPUS+c]` is set.
- R3: With no candidate, `sel_id_o` for that CPU reads 1023 and the request stays low.
- R4: `irq_req_o[c]` is registered. It is high one cycle after a cycle in which all five hold: `dist_en_i` is high; `cpu_en_i[c]` is high; a winner exists; the winner's priority is strictly below `prio_mask_i[c*8 +: 8]`; and the winner's active bit is clear.
- R5: An acknowledge strobe sets the active bit and clears the pending bit of the ID selected in that cycle. An acknowledge with no candidate changes nothing.
- R6: An end-of-interrupt strobe clears the active bit of `eoi_id_i`. IDs at or above NUM_IRQS have no effect. If it names the ID being acknowledged in the same cycle, the acknowledge wins.
- R7: `run_prio_o` for a CPU equals the minimum priority over that CPU's active lines, or 0xFF when none is active, and follows the active bits with no added delay.
- R8: A pulse on `pend_set_i[c*NUM_IRQS+i]` sets pending bit i of CPU c, and it wins over an acknowledge clearing the same bit in the same cycle.
- R9: After reset all pending and active bits are clear, requests are low, every selected ID is 1023 and every running priority is 0xFF.
- R10: The banks of different CPUs are independent: pending, acknowledge and end-of-interrupt activity for one CPU leaves the other CPUs' selection and running priority unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| dist_en_i | input | 1 | Global delivery enable |
| cpu_en_i | input | NUM_CPUS | Per-CPU interface enable |
| multi_cpu_i | input | 1 | More than one CPU running; applies target masks to shared lines |
| irq_en_i | input | NUM_IRQS | Per-line enable |
| irq_prio_i | input | NUM_IRQS*8 | Priority byte of line i at [i*8 +: 8] |
| irq_tgt_i | input | NUM_IRQS*NUM_CPUS | Target bit of line i for CPU c at [i*NUM_CPUS+c] |
| pend_set_i | input | NUM_CPUS*NUM_IRQS | Set-pending pulses, CPU c line i at [c*NUM_IRQS+i] |
| prio_mask_i | input | NUM_CPUS*8 | Per-CPU priority mask |
| ack_i | input | NUM_CPUS | Acknowledge strobe per CPU |
| eoi_i | input | NUM_CPUS | End-of-interrupt strobe per CPU |
| eoi_id_i | input | NUM_CPUS*10 | End-of-interrupt ID per CPU |
| irq_req_o | output | NUM_CPUS | Registered interrupt request per CPU |
| sel_id_o | output | NUM_CPUS*10 | Selected ID per CPU, 1023 when none |
| run_prio_o | output | NUM_CPUS*8 | Running priority per CPU |

## Verification
The assertions assume that the enables, masks and priorities are stable around each clock edge. They also assume that a strobe lasts exactly one cycle and is driven away from the sampling edge. The bench meets this by changing every input at the falling edge, holding each strobe for one cycle, and waiting for the request flop before it samples the request. The acknowledge property also assumes that an acknowledge is issued against the ID shown in that same cycle. Because the bench's acknowledges never race a priority change, this holds.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int PRIO_W      = 8;
  localparam int ID_W        = 10;
  localparam logic [PRIO_W-1:0] PRIO_IDLE   = '1;
  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;

  // Smaller value is more urgent; equal values do not displace.
  function automatic logic prio_beats(input logic [PRIO_W-1:0] cand,
                                      input logic [PRIO_W-1:0] best);
    return cand < best;
  endfunction

  function automatic logic [PRIO_W-1:0] prio_min(input logic [PRIO_W-1:0] a,
                                                 input logic [PRIO_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_sel_scan.sv
module irq_sel_scan
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQS = 64
) (
  input  logic [NUM_IRQS-1:0]        cand_i,
  input  logic [NUM_IRQS-1:0]        act_i,
  input  logic [NUM_IRQS*PRIO_W-1:0] prio_i,
  output logic                       found_o,
  output logic [ID_W-1:0]            best_id_o,
  output logic [PRIO_W-1:0]          best_prio_o,
  output logic                       best_active_o
);
  logic [ID_W-1:0] idx;

  always_comb begin
    best_prio_o   = PRIO_IDLE;
    idx           = '0;
    found_o       = 1'b0;
    best_active_o = 1'b0;
    for (int i = 0; i < NUM_IRQS; i++) begin
      if (cand_i[i] && prio_beats(prio_i[i*PRIO_W +: PRIO_W], best_prio_o)) begin
        best_prio_o   = prio_i[i*PRIO_W +: PRIO_W];
        idx           = ID_W'(i);
        found_o       = 1'b1;
        best_active_o = act_i[i];
      end
    end
  end

  assign best_id_o = found_o ? idx : SPURIOUS_ID;
endmodule

// File: rtl/irq_sel_bank.sv
module irq_sel_bank
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQS = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_n_i,
  input  logic [NUM_IRQS-1:0]        pend_set_i,
  input  logic                       ack_i,
  input  logic                       ack_ok_i,
  input  logic [ID_W-1:0]            ack_id_i,
  input  logic                       eoi_i,
  input  logic [ID_W-1:0]            eoi_id_i,
  input  logic [NUM_IRQS*PRIO_W-1:0] prio_i,
  output logic [NUM_IRQS-1:0]        pend_o,
  output logic [NUM_IRQS-1:0]        act_o,
  output logic [PRIO_W-1:0]          run_prio_o
);
  logic [NUM_IRQS-1:0] pend_q, act_q, pend_nx, act_nx;

  always_comb begin
    pend_nx = pend_q;
    act_nx  = act_q;
    for (int i = 0; i < NUM_IRQS; i++) begin
      if (eoi_i && eoi_id_i == ID_W'(i)) act_nx[i] = 1'b0;
      if (ack_i && ack_ok_i && ack_id_i == ID_W'(i)) begin
        act_nx[i]  = 1'b1;
        pend_nx[i] = 1'b0;
      end
    end
    pend_nx = pend_nx | pend_set_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_nx;
      act_q  <= act_nx;
    end
  end

  always_comb begin
    run_prio_o = PRIO_IDLE;
    for (int i = 0; i < NUM_IRQS; i++)
      if (act_q[i]) run_prio_o = prio_min(run_prio_o, prio_i[i*PRIO_W +: PRIO_W]);
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_prio_selector.sv
module irq_prio_selector
  import irq_sel_pkg::*;
#(
  parameter int NUM_CPUS    = 2,
  parameter int NUM_IRQS    = 64,
  parameter int NUM_PRIVATE = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic                         dist_en_i,
  input  logic [NUM_CPUS-1:0]          cpu_en_i,
  input  logic                         multi_cpu_i,
  input  logic [NUM_IRQS-1:0]          irq_en_i,
  input  logic [NUM_IRQS*PRIO_W-1:0]   irq_prio_i,
  input  logic [NUM_IRQS*NUM_CPUS-1:0] irq_tgt_i,
  input  logic [NUM_CPUS*NUM_IRQS-1:0] pend_set_i,
  input  logic [NUM_CPUS*PRIO_W-1:0]   prio_mask_i,
  input  logic [NUM_CPUS-1:0]          ack_i,
  input  logic [NUM_CPUS-1:0]          eoi_i,
  input  logic [NUM_CPUS*ID_W-1:0]     eoi_id_i,
  output logic [NUM_CPUS-1:0]          irq_req_o,
  output logic [NUM_CPUS*ID_W-1:0]     sel_id_o,
  output logic [NUM_CPUS*PRIO_W-1:0]   run_prio_o
);
  // Named internal events for the checker
  logic [NUM_CPUS*PRIO_W-1:0] best_prio_w;
  logic [NUM_CPUS-1:0]        found_w;
  logic [NUM_CPUS-1:0]        deliver_w;
  logic [NUM_CPUS-1:0]        req_q;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_IRQS-1:0] pend, act, cand;
    logic [ID_W-1:0]     best_id;
    logic [PRIO_W-1:0]   best_prio;
    logic                found, best_active;

    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_line
      localparam bit IS_PRIVATE = (i < NUM_PRIVATE);
      logic routed;
      assign routed  = IS_PRIVATE || !multi_cpu_i || irq_tgt_i[i*NUM_CPUS+c];
      assign cand[i] = irq_en_i[i] && pend[i] && routed;
    end

    irq_sel_bank #(.NUM_IRQS(NUM_IRQS)) u_bank (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .pend_set_i (pend_set_i[c*NUM_IRQS +: NUM_IRQS]),
      .ack_i      (ack_i[c]),
      .ack_ok_i   (found),
      .ack_id_i   (best_id),
      .eoi_i      (eoi_i[c]),
      .eoi_id_i   (eoi_id_i[c*ID_W +: ID_W]),
      .prio_i     (irq_prio_i),
      .pend_o     (pend),
      .act_o      (act),
      .run_prio_o (run_prio_o[c*PRIO_W +: PRIO_W])
    );

    irq_sel_scan #(.NUM_IRQS(NUM_IRQS)) u_scan (
      .cand_i        (cand),
      .act_i         (act),
      .prio_i        (irq_prio_i),
      .found_o       (found),
      .best_id_o     (best_id),
      .best_prio_o   (best_prio),
      .best_active_o (best_active)
    );

    assign deliver_w[c] = dist_en_i && cpu_en_i[c] && found && !best_active &&
                          prio_beats(best_prio, prio_mask_i[c*PRIO_W +: PRIO_W]);

    always_ff @(posedge clk_i) begin
      if (!rst_n_i) req_q[c] <= 1'b0;
      else          req_q[c] <= deliver_w[c];
    end

    assign found_w[c]                      = found;
    assign best_prio_w[c*PRIO_W +: PRIO_W] = best_prio;
    assign sel_id_o[c*ID_W +: ID_W]        = best_id;
  end

  assign irq_req_o = req_q;
endmodule

// File: rtl/irq_prio_selector_chk.sv
module irq_prio_selector_chk
  import irq_sel_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_IRQS = 64
) (
  input logic                       clk_i,
  input logic                       rst_n_i,
  input logic                       dist_en_i,
  input logic [NUM_CPUS-1:0]        cpu_en_i,
  input logic [NUM_CPUS-1:0]        ack_i,
  input logic [NUM_CPUS*PRIO_W-1:0] prio_mask_i,
  input logic [NUM_CPUS-1:0]        irq_req_o,
  input logic [NUM_CPUS*ID_W-1:0]   sel_id_o,
  input logic [NUM_CPUS*PRIO_W-1:0] run_prio_o,
  input logic [NUM_CPUS*PRIO_W-1:0] best_prio_w,
  input logic [NUM_CPUS-1:0]        found_w
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
    AST_REQ_NEEDS_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      irq_req_o[c] |-> $past(dist_en_i && cpu_en_i[c])); // R4
    AST_REQ_BELOW_MASK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      irq_req_o[c] |-> $past(best_prio_w[c*PRIO_W +: PRIO_W] < prio_mask_i[c*PRIO_W +: PRIO_W])); // R4
    AST_SPURIOUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sel_id_o[c*ID_W +: ID_W] == SPURIOUS_ID) |=> !irq_req_o[c]); // R3
    AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      found_w[c] |-> (sel_id_o[c*ID_W +: ID_W] < ID_W'(NUM_IRQS))); // R2
    AST_ACK_RAISES_RUNPRIO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ack_i[c] && found_w[c]) |=>
        (run_prio_o[c*PRIO_W +: PRIO_W] <= $past(best_prio_w[c*PRIO_W +: PRIO_W]))); // R7
  end
endmodule

bind irq_prio_selector irq_prio_selector_chk #(
  .NUM_CPUS (NUM_CPUS),
  .NUM_IRQS (NUM_IRQS)
) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .dist_en_i   (dist_en_i),
  .cpu_en_i    (cpu_en_i),
  .ack_i       (ack_i),
  .prio_mask_i (prio_mask_i),
  .irq_req_o   (irq_req_o),
  .sel_id_o    (sel_id_o),
  .run_prio_o  (run_prio_o),
  .best_prio_w (best_prio_w),
  .found_w     (found_w)
);

// File: tb/irq_prio_selector_bench.sv
module irq_prio_selector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NI = 64;
  localparam int PW = 8;
  localparam int IW = 10;

  typedef struct packed {
    logic [IW-1:0] id_a;
    logic [PW-1:0] pr_a;
    logic [IW-1:0] id_b;
    logic [PW-1:0] pr_b;
    logic [PW-1:0] mask;
    logic [IW-1:0] exp_id;
    logic          exp_req;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{10'd40, 8'h30, 10'd50, 8'h20, 8'hFF, 10'd50,   1'b1},  // R1 lower value wins
    '{10'd40, 8'h20, 10'd50, 8'h20, 8'hFF, 10'd40,   1'b1},  // R1 tie -> lower ID
    '{10'd5,  8'h80, 10'd33, 8'h10, 8'h10, 10'd33,   1'b0},  // R4 equal to mask blocks
    '{10'd5,  8'h10, 10'd33, 8'h40, 8'h11, 10'd5,    1'b1},  // R4 just under mask
    '{10'd63, 8'h00, 10'd0,  8'h01, 8'h01, 10'd63,   1'b1},  // R1 top ID, value 0
    '{10'd10, 8'hFF, 10'd12, 8'hFF, 8'hFF, 10'd1023, 1'b0}   // R3 0xFF never wins
  };

  logic clk = 0, rst_n = 0, dist_en, multi;
  logic [NC-1:0] cpu_en, ack, eoi;
  logic [NI-1:0] irq_en;
  logic [NI*PW-1:0] prio;
  logic [NI*NC-1:0] tgt;
  logic [NC*NI-1:0] pend_set;
  logic [NC*PW-1:0] mask;
  logic [NC*IW-1:0] eoi_id;
  logic [NC-1:0] req;
  logic [NC*IW-1:0] sel;
  logic [NC*PW-1:0] runp;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_selector u_irq_prio_selector (
    .clk_i(clk), .rst_n_i(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
    .multi_cpu_i(multi), .irq_en_i(irq_en), .irq_prio_i(prio), .irq_tgt_i(tgt),
    .pend_set_i(pend_set), .prio_mask_i(mask), .ack_i(ack), .eoi_i(eoi),
    .eoi_id_i(eoi_id), .irq_req_o(req), .sel_id_o(sel), .run_prio_o(runp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic defaults();
    dist_en = 1; multi = 1; cpu_en = '1; ack = '0; eoi = '0; eoi_id = '0;
    irq_en = '1; pend_set = '0; mask = '1;
    for (int i = 0; i < NI; i++) begin
      prio[i*PW +: PW] = 8'hA0;
      tgt[i*NC +: NC]  = 2'b01;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    defaults();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // Set pending on the given CPU, then return at the next falling edge.
  task automatic pend(input int c, input int id);
    pend_set[c*NI + id] = 1'b1;
    @(negedge clk);
    pend_set = '0;
  endtask

  task automatic do_ack(input int c);
    ack[c] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic do_eoi(input int c, input int id);
    eoi[c] = 1'b1;
    eoi_id[c*IW +: IW] = IW'(id);
    @(negedge clk);
    eoi = '0;
  endtask

  function automatic int sel_of(input int c);
    return int'(sel[c*IW +: IW]);
  endfunction

  function automatic int run_of(input int c);
    return int'(runp[c*PW +: PW]);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    // R9 reset state
    do_reset();
    for (int c = 0; c < NC; c++) begin
      chk("R9 req", req[c], 0);
      chk("R9 sel", sel_of(c), 1023);
      chk("R9 run", run_of(c), 255);
    end

    // Vector table on CPU0
    foreach (VECS[k]) begin
      do_reset();
      prio[int'(VECS[k].id_a)*PW +: PW] = VECS[k].pr_a;
      prio[int'(VECS[k].id_b)*PW +: PW] = VECS[k].pr_b;
      mask[0 +: PW] = VECS[k].mask;
      pend_set[int'(VECS[k].id_a)] = 1'b1;
      pend_set[int'(VECS[k].id_b)] = 1'b1;
      @(negedge clk);
      pend_set = '0;
      chk("R1 table sel", sel_of(0), int'(VECS[k].exp_id));
      @(negedge clk);
      chk("R4 table req", req[0], int'(VECS[k].exp_req));
    end

    // R2 target routing
    do_reset();
    tgt[40*NC +: NC] = 2'b10;
    pend(0, 40);
    chk("R2 untargeted shared", sel_of(0), 1023);
    multi = 0;
    #1 chk("R2 single cpu ignores target", sel_of(0), 40);
    multi = 1;
    tgt[3*NC +: NC] = 2'b00;
    pend(0, 3);
    chk("R2 private ignores target", sel_of(0), 3);
    irq_en[3] = 0;
    #1 chk("R2 disabled line", sel_of(0), 1023);

    // R4 enables
    do_reset();
    pend(0, 20);
    @(negedge clk);
    chk("R4 req on", req[0], 1);
    dist_en = 0;
    @(negedge clk);
    chk("R4 global enable off", req[0], 0);
    dist_en = 1; cpu_en[0] = 0;
    @(negedge clk);
    chk("R4 cpu enable off", req[0], 0);
    chk("R10 other cpu quiet", req[1], 0);

    // R5 R6 R7 acknowledge / end-of-interrupt
    do_reset();
    prio[40*PW +: PW] = 8'h30;
    prio[41*PW +: PW] = 8'h50;
    pend(0, 40);
    pend(0, 41);
    do_ack(0);
    chk("R5 next winner", sel_of(0), 41);
    chk("R7 run after ack", run_of(0), 8'h30);
    chk("R10 cpu1 run", run_of(1), 255);
    @(negedge clk);
    chk("R4 req for next", req[0], 1);
    do_ack(0);
    chk("R5 all taken", sel_of(0), 1023);
    chk("R7 run two active", run_of(0), 8'h30);
    do_ack(0);
    chk("R5 spurious ack no effect", run_of(0), 8'h30);
    do_eoi(0, 40);
    chk("R6 eoi 40", run_of(0), 8'h50);
    do_eoi(0, 100);
    chk("R6 out of range ignored", run_of(0), 8'h50);
    do_eoi(0, 41);
    chk("R6 eoi 41", run_of(0), 255);

    // R4 already active gate
    do_reset();
    pend(0, 40);
    do_ack(0);
    pend(0, 40);
    chk("R4 active winner selected", sel_of(0), 40);
    @(negedge clk);
    chk("R4 active winner no req", req[0], 0);
    do_eoi(0, 40);
    @(negedge clk);
    chk("R4 req after eoi", req[0], 1);

    // R8 set wins over ack clear
    do_reset();
    pend(0, 40);
    pend_set[40] = 1'b1;
    do_ack(0);
    pend_set = '0;
    chk("R8 pending kept", sel_of(0), 40);
    chk("R8 active set", run_of(0), 8'hA0);
    @(negedge clk);
    chk("R8 no req while active", req[0], 0);

    // R10 bank independence
    do_reset();
    pend(1, 7);
    chk("R10 cpu1 sel", sel_of(1), 7);
    chk("R10 cpu0 sel", sel_of(0), 1023);
    do_ack(1);
    chk("R10 cpu1 run", run_of(1), 8'hA0);
    chk("R10 cpu0 run", run_of(0), 255);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule